// File: doc/BRIEF.md
# LCD Color Palette Lookup

This unit sits between the pixel-index stream coming from an LCD frame fetcher and the data pins of the panel. Each 8-bit index selects one of 256 palette entries. The unit returns either a 24-bit red/green/blue word or an 8-bit gray level. A host programs the entries through a simple strobe-based register port. Entries can only be changed inside a setting mode. The host requests that mode through an enable bit and must then see a ready bit before it writes. The display output is held at zero while the mode is active.

To save storage, each entry keeps only the upper 5 bits of red, the upper 6 bits of green and the upper 5 bits of blue. On the way out, each channel is widened back to 8 bits. A channel whose stored bits are all zero becomes 0x00. Any other channel has its missing low bits filled with ones.

Top module: `lcd_palette_lut`

## Requirements
- R1: After reset the control word reads 0 (bit 0 = enable, bit 1 = ready) and `outValid` is 0.
- R2: With enable at 1, the ready bit goes to 1 on the first clock edge at which `frameSync` is 1. Without `frameSync` it stays 0.
- R3: When enable is written to 0, ready goes to 0 on the next clock edge. A control read issued in the cycle right after the clear returns 2'b10, and the next one returns 2'b00.
- R4: A write to a palette entry has no effect while ready is 0, whatever the value of enable.
- R5: While ready is 1, every lookup result on `outData` is all zeros.
- R6: In color mode, `outData[23:16]`, `[15:8]` and `[7:0]` are red, green and blue. They are widened from written bits [23:19], [15:10] and [7:3] respectively. The low fill is all ones if the stored part is nonzero, and zeros otherwise. The other written bits are discarded.
- R7: In monochrome mode (`monoMode` = 1), `outData[7:0]` is the gray level, widened from written bits [7:3] by the same fill rule. `outData[23:8]` is zero, and written bits [23:8] have no effect on it.
- R8: `outValid` is a copy of `pixValid` delayed by one clock. The data for an index is on `outData` in the same cycle that `outValid` is high for it.
- R9: A host read returns data on `hostRData` with `hostRValid` one clock after the read strobe. An entry read returns the widened color form of R6. A control read returns {ready, enable} in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostSelCtrl | input | 1 | 1 selects the control word, 0 selects the palette entry at `hostIdx` |
| hostIdx | input | 8 | Palette entry number for host access |
| hostWData | input | 24 | Host write data |
| hostRData | output | 24 | Host read data, registered |
| hostRValid | output | 1 | `hostRData` valid |
| frameSync | input | 1 | Frame or line boundary pulse from the timing logic |
| monoMode | input | 1 | 1 selects gray output |
| pixValid | input | 1 | Pixel index valid |
| pixIdx | input | 8 | Pixel index |
| outValid | output | 1 | Output data valid |
| outData | output | 24 | Panel pixel data |

## Verification
Lookup results and host read data are both due exactly one clock after their strobe. The ready bit changes one clock after the qualifying enable and `frameSync` condition. The bench drives every stimulus on a falling edge. It samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Back-to-back control reads around the enable clear pin down the one-clock ready delay.

The full sweeps stream one index per cycle. Each index is checked one cycle later against channel widening computed arithmetically in the bench, in both color and gray modes.

// File: rtl/lcd_pal_pkg.sv
`timescale 1ns/1ps
package lcd_pal_pkg;

  // Strobes and state handed from the control block to the datapath.
  typedef struct packed {
    logic wrEntry;  // accepted palette write
    logic rdEntry;  // palette read request
    logic rdCtrl;   // control word read request
    logic blank;    // force display output to zero
    logic enBit;    // requested setting mode
    logic stBit;    // setting mode confirmed
  } palStrb_t;

  localparam int CTRL_EN_POS = 0;
  localparam int CTRL_ST_POS = 1;

endpackage

// File: rtl/pal_widen.sv
`timescale 1ns/1ps
// Widens a truncated channel back to OUT_W bits: zero stays zero,
// anything else gets its missing low bits filled with ones.
module pal_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);
  localparam int FILL_W = OUT_W - IN_W;

  generate
    if (FILL_W > 0) begin : g_fill
      assign wide = (|narrow) ? {narrow, {FILL_W{1'b1}}} : '0;
    end else begin : g_pass
      assign wide = narrow;
    end
  endgenerate
endmodule

// File: rtl/pal_ctrl.sv
`timescale 1ns/1ps
module pal_ctrl
  import lcd_pal_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hostWr,
  input  logic     hostRd,
  input  logic     hostSelCtrl,
  input  logic     wrEnValue,
  input  logic     frameSync,
  output palStrb_t strb
);
  logic enReg;
  logic stReg;

  // enReg follows host writes; stReg trails it and only rises on a boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg <= 1'b0;
      stReg <= 1'b0;
    end else begin
      if (hostWr && hostSelCtrl) enReg <= wrEnValue;
      stReg <= enReg ? (stReg | frameSync) : 1'b0;
    end
  end

  always_comb begin
    strb.wrEntry = hostWr && !hostSelCtrl && stReg;
    strb.rdEntry = hostRd && !hostSelCtrl;
    strb.rdCtrl  = hostRd && hostSelCtrl;
    strb.blank   = stReg;
    strb.enBit   = enReg;
    strb.stBit   = stReg;
  end
endmodule

// File: rtl/pal_datapath.sv
`timescale 1ns/1ps
module pal_datapath
  import lcd_pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int CH_W    = 8,
  parameter int R_W     = 5,
  parameter int G_W     = 6,
  parameter int B_W     = 5,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int DATA_W  = 3 * CH_W,
  localparam int STORE_W = R_W + G_W + B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  palStrb_t          strb,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hostRValid,
  input  logic              monoMode,
  input  logic              pixValid,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  // Channel 0 = blue (lowest), 1 = green, 2 = red.
  function automatic int chanBits(input int c);
    return (c == 0) ? B_W : (c == 1) ? G_W : R_W;
  endfunction

  function automatic int storeOff(input int c);
    int s;
    s = 0;
    for (int k = 0; k < c; k++) s += chanBits(k);
    return s;
  endfunction

  logic [STORE_W-1:0] palMem [ENTRIES];
  logic [STORE_W-1:0] packIn;
  logic [STORE_W-1:0] lookupWord;
  logic [STORE_W-1:0] readWord;
  logic [DATA_W-1:0]  lookupWide;
  logic [DATA_W-1:0]  readWide;
  logic [DATA_W-1:0]  pixNext;
  logic [DATA_W-1:0]  ctrlWord;
  logic               unusedWrBits;

  assign lookupWord = palMem[pixIdx];
  assign readWord   = palMem[hostIdx];

  generate
    for (genvar g = 0; g < 3; g++) begin : g_chan
      localparam int NB = chanBits(g);
      localparam int SO = storeOff(g);
      assign packIn[SO +: NB] = hostWData[g*CH_W + CH_W - NB +: NB];
      pal_widen #(.IN_W(NB), .OUT_W(CH_W)) u_wLook (
        .narrow(lookupWord[SO +: NB]),
        .wide  (lookupWide[g*CH_W +: CH_W])
      );
      pal_widen #(.IN_W(NB), .OUT_W(CH_W)) u_wRead (
        .narrow(readWord[SO +: NB]),
        .wide  (readWide[g*CH_W +: CH_W])
      );
    end
  endgenerate

  // Written low bits have no storage behind them.
  assign unusedWrBits = ^hostWData;

  always_ff @(posedge clk) begin
    if (strb.wrEntry) palMem[hostIdx] <= packIn;
  end

  always_comb begin
    if (strb.blank)   pixNext = '0;
    else if (monoMode) pixNext = {{(DATA_W-CH_W){1'b0}}, lookupWide[CH_W-1:0]};
    else               pixNext = lookupWide;
    ctrlWord = '0;
    ctrlWord[CTRL_EN_POS] = strb.enBit;
    ctrlWord[CTRL_ST_POS] = strb.stBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outData    <= '0;
      hostRValid <= 1'b0;
      hostRData  <= '0;
    end else begin
      outValid   <= pixValid;
      outData    <= pixValid ? pixNext : '0;
      hostRValid <= strb.rdCtrl | strb.rdEntry;
      hostRData  <= strb.rdCtrl ? ctrlWord : (strb.rdEntry ? readWide : '0);
    end
  end
endmodule

// File: rtl/lcd_palette_lut.sv
`timescale 1ns/1ps
module lcd_palette_lut
  import lcd_pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int CH_W    = 8,
  parameter int R_W     = 5,
  parameter int G_W     = 6,
  parameter int B_W     = 5,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int DATA_W = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostSelCtrl,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hostRValid,
  input  logic              frameSync,
  input  logic              monoMode,
  input  logic              pixValid,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  palStrb_t ctrlStrb;
  logic     palEnable;
  logic     palReady;

  assign palEnable = ctrlStrb.enBit;
  assign palReady  = ctrlStrb.stBit;

  pal_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostSelCtrl(hostSelCtrl),
    .wrEnValue  (hostWData[CTRL_EN_POS]),
    .frameSync  (frameSync),
    .strb       (ctrlStrb)
  );

  pal_datapath #(
    .ENTRIES(ENTRIES), .CH_W(CH_W), .R_W(R_W), .G_W(G_W), .B_W(B_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (ctrlStrb),
    .hostIdx   (hostIdx),
    .hostWData (hostWData),
    .hostRData (hostRData),
    .hostRValid(hostRValid),
    .monoMode  (monoMode),
    .pixValid  (pixValid),
    .pixIdx    (pixIdx),
    .outValid  (outValid),
    .outData   (outData)
  );
endmodule

// File: rtl/pal_checker.sv
`timescale 1ns/1ps
// Checks assume the default 8-bit channel layout.
module pal_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frameSync,
  input logic              pixValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              enBit,
  input logic              stBit
);
  p_ready_needs_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stBit && !(enBit && frameSync)) |=> !stBit);

  p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enBit |=> !stBit);

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stBit |=> (outData == '0));

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |=> outValid);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> !outValid);

  p_fill_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outData[18:16] == ((|outData[23:19]) ? 3'b111 : 3'b000)));

  p_fill_green_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outData[9:8] == ((|outData[15:10]) ? 2'b11 : 2'b00)));

  p_fill_blue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outData[2:0] == ((|outData[7:3]) ? 3'b111 : 3'b000)));
endmodule

bind lcd_palette_lut pal_checker #(.DATA_W(DATA_W)) u_palChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frameSync(frameSync),
  .pixValid (pixValid),
  .outValid (outValid),
  .outData  (outData),
  .enBit    (palEnable),
  .stBit    (palReady)
);

// File: tb/tb_lcd_palette_lut.sv
`timescale 1ns/1ps
module tb_lcd_palette_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0, hostSelCtrl = 1'b0;
  logic [7:0]  hostIdx = '0;
  logic [23:0] hostWData = '0;
  logic [23:0] hostRData;
  logic        hostRValid;
  logic        frameSync = 1'b0, monoMode = 1'b0, pixValid = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic        outValid;
  logic [23:0] outData;

  int nChecks = 0;
  int nFail = 0;
  logic [23:0] rd;

  always #2.5 clk = ~clk;

  lcd_palette_lut dut (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostRd(hostRd),
    .hostSelCtrl(hostSelCtrl), .hostIdx(hostIdx), .hostWData(hostWData),
    .hostRData(hostRData), .hostRValid(hostRValid), .frameSync(frameSync),
    .monoMode(monoMode), .pixValid(pixValid), .pixIdx(pixIdx),
    .outValid(outValid), .outData(outData)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int i);
    logic [7:0] r, g, b;
    r = 8'(i) ^ 8'h5A;
    g = 8'(i * 37 + 11);
    b = 8'(255 - i);
    return {r, g, b};
  endfunction

  function automatic logic [7:0] widen(input int v, input int n);
    if (v == 0) return 8'h00;
    return 8'((v << (8 - n)) | ((1 << (8 - n)) - 1));
  endfunction

  function automatic logic [23:0] expColor(input logic [23:0] d);
    return {widen(int'(d[23:19]), 5), widen(int'(d[15:10]), 6), widen(int'(d[7:3]), 5)};
  endfunction

  // Caller is at a falling edge; returns at the next falling edge.
  task automatic hostWrite(input logic sel, input logic [7:0] idx, input logic [23:0] d);
    hostWr = 1'b1; hostSelCtrl = sel; hostIdx = idx; hostWData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic sel, input logic [7:0] idx, output logic [23:0] d);
    hostRd = 1'b1; hostSelCtrl = sel; hostIdx = idx;
    @(negedge clk);
    hostRd = 1'b0;
    chk("R9 rvalid", {23'b0, hostRValid}, 24'h1);
    d = hostRData;
  endtask

  task automatic sweep(input logic mono, input logic blanked, input int count);
    monoMode = mono;
    for (int i = 0; i < count; i++) begin
      pixValid = 1'b1; pixIdx = 8'(i);
      @(negedge clk);
      chk("R8 outValid", {23'b0, outValid}, 24'h1);
      if (blanked) chk("R5 blank", outData, 24'h0);
      else if (mono) chk("R7 gray", outData, {16'h0, widen(int'(pat(i)[7:3]), 5)});
      else chk("R6 color", outData, expColor(pat(i)));
    end
    pixValid = 1'b0;
    @(negedge clk);
    chk("R8 idle", {23'b0, outValid}, 24'h0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outValid", {23'b0, outValid}, 24'h0);
    hostRead(1'b1, 8'h0, rd); chk("R1 ctrl", rd, 24'h0);

    // R2: enable, no boundary yet
    hostWrite(1'b1, 8'h0, 24'h1);
    hostRead(1'b1, 8'h0, rd); chk("R2 pending", rd, 24'h1);
    repeat (5) @(negedge clk);
    hostRead(1'b1, 8'h0, rd); chk("R2 no sync", rd, 24'h1);
    frameSync = 1'b1; @(negedge clk); frameSync = 1'b0;
    hostRead(1'b1, 8'h0, rd); chk("R2 ready", rd, 24'h3);

    // R5: output blanked during setting mode
    sweep(1'b0, 1'b1, 8);

    // Program all entries (low bits deliberately random-looking)
    for (int i = 0; i < 256; i++) hostWrite(1'b0, 8'(i), pat(i));

    // R3: exit
    hostWrite(1'b1, 8'h0, 24'h0);
    hostRead(1'b1, 8'h0, rd); chk("R3 one clock", rd, 24'h2);
    hostRead(1'b1, 8'h0, rd); chk("R3 cleared", rd, 24'h0);

    // R4: write in normal mode ignored
    hostWrite(1'b0, 8'h10, 24'hFFFFFF);
    hostRead(1'b0, 8'h10, rd); chk("R4 normal", rd, expColor(pat(16'h10)));
    // R4: enable set but ready still 0
    hostWrite(1'b1, 8'h0, 24'h1);
    hostWrite(1'b0, 8'h20, 24'h000000);
    hostWrite(1'b1, 8'h0, 24'h0);
    @(negedge clk);
    hostRead(1'b0, 8'h20, rd); chk("R4 pending", rd, expColor(pat(16'h20)));

    // R9: readback of entries with fill rule
    hostRead(1'b0, 8'h00, rd); chk("R9 entry0", rd, expColor(pat(0)));
    hostRead(1'b0, 8'h5A, rd); chk("R9 entry5A", rd, expColor(pat(16'h5A)));
    hostRead(1'b0, 8'hFF, rd); chk("R9 entryFF", rd, expColor(pat(255)));

    // R6, R7, R8: full sweeps
    sweep(1'b0, 1'b0, 256);
    sweep(1'b1, 1'b0, 256);

    finishRun();
  end
endmodule